// File: doc/BRIEF.md
# Four-Lane Fixed-Point Shader Arithmetic Unit

This block is the arithmetic core of a legacy pixel-shader datapath. It works on four-lane vectors of 12-bit signed fixed-point numbers. Each number has a sign bit, one integer bit and ten fraction bits, so one unit is 1/1024. The unit accepts one instruction per clock. An instruction carries an opcode, up to three source vectors with a negate flag for each source, a power-of-two result scale, an absolute-value flag, a saturate flag and a per-lane write mask. Two cycles later the unit returns a result vector, per-lane write enables and a valid flag.

Each result goes through a fixed chain of steps. First the operation runs at full internal precision. The scale and the conversion back to ten fraction bits are then done in a single rounding step. After that the absolute value is taken if requested. Last, the value is clamped: to [0, 1.0] when saturating, or otherwise to the register range of -2.0 to just under 2.0. Every instruction clamps on its own. A chain of saturating instructions therefore gives the step-by-step answer and cannot be folded into one sum.

Top module: `pso_alu`

## Requirements
- R1: Opcode 0 adds and opcode 1 subtracts (a - b) lane by lane. Source negate flags are bit 0 for a, bit 1 for b and bit 2 for c. A negate flag is applied to its operand before the operation. Lane i occupies bits [12i+11:12i] of each vector.
- R2: Opcode 2 multiplies lane by lane. The product is kept exact until the final rounding step.
- R3: Opcode 3 computes a*b+c with one rounding and one clamp at the end. A product outside [-2,2] can be brought back into range by c.
- R4: Opcode 4 (sum of a*b over lanes 0..2) and opcode 5 (sum over lanes 0..3) put the same dot product in every lane.
- R5: Scale code 0 or 7 leaves the value unscaled. Codes 1, 2 and 3 multiply by 2, 4 and 8. Codes 4, 5 and 6 multiply by 0.5, 0.25 and 0.125. The result is then rounded to the nearest 1/1024, with exact halves rounded upward.
- R6: With the absolute-value flag set, a negative scaled result is negated before the clamp, at no extra latency.
- R7: Without saturate, results are clamped to [-2048, 2047] in units of 1/1024.
- R8: With saturate, results are clamped to [0, 1024].
- R9: out_we equals the instruction's write mask. A lane whose mask bit is 0 outputs zero.
- R10: An instruction presented with in_valid at one rising edge appears with out_valid after the second rising edge. Instructions may be issued on every cycle.
- R11: After reset, out_valid, out_we and out_data are all zero.
- R12: Each instruction clamps on its own. Starting from all ones, the chain (1+1) saturated = 1, then (1+1) saturated = 1, then 1+(-1) = 0.
- R13: Opcodes 6 and 7 produce a zero result in every lane, whatever the sources.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 3 | Opcode |
| in_src_a | input | LANES*DATA_W | Source vector a |
| in_src_b | input | LANES*DATA_W | Source vector b |
| in_src_c | input | LANES*DATA_W | Source vector c (multiply-add only) |
| in_neg | input | 3 | Negate flags for c, b, a (bit 2..0) |
| in_mask | input | LANES | Write mask, bit i for lane i |
| in_scale | input | 3 | Result scale code |
| in_abs | input | 1 | Take absolute value of result |
| in_sat | input | 1 | Saturate result to [0,1] |
| out_valid | output | 1 | Result present |
| out_we | output | LANES | Per-lane write enables |
| out_data | output | LANES*DATA_W | Result vector |

## Verification
The bench uses the default build: 12-bit data with 10 fraction bits, four lanes, and the dot-product ops enabled. With these settings every input is an exact multiple of 1/1024. A double-precision reference can therefore reproduce each product, sum and scale exactly, so each rounding tie and each clamp edge can be predicted exactly. Four lanes let DP3 and DP4 be told apart by the fourth lane, and let lanes of mixed sign meet the clamp and the absolute-value flag in a single instruction.

// File: rtl/pso_pkg.sv
package pso_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_MUL  = 3'd2,
    OP_MAD  = 3'd3,
    OP_DP3  = 3'd4,
    OP_DP4  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } pso_op_e;

  // Total right shift for a scale code, given the shift that converts
  // the internal fraction width back to the output fraction width.
  function automatic int scale_rshift(input logic [2:0] code, input int base);
    case (code)
      3'd1:    return base - 1;
      3'd2:    return base - 2;
      3'd3:    return base - 3;
      3'd4:    return base + 1;
      3'd5:    return base + 2;
      3'd6:    return base + 3;
      default: return base;
    endcase
  endfunction

endpackage

// File: rtl/pso_opstage.sv
module pso_opstage
  import pso_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int FRAC_W = 10,
  parameter int LANES  = 4,
  parameter int DOT_EN = 1,
  parameter int ACC_W  = 28
) (
  input  logic [2:0]              op,
  input  logic [LANES*DATA_W-1:0] src_a,
  input  logic [LANES*DATA_W-1:0] src_b,
  input  logic [LANES*DATA_W-1:0] src_c,
  input  logic [2:0]              neg,
  output logic [LANES*ACC_W-1:0]  acc,
  output logic                    is_dot
);

  // Sign-extend an operand to accumulator width and apply its negate flag.
  function automatic logic signed [ACC_W-1:0] widen(input logic [DATA_W-1:0] raw,
                                                    input logic flip);
    logic signed [ACC_W-1:0] v;
    v = ACC_W'($signed(raw));
    return flip ? -v : v;
  endfunction

  pso_op_e opc;
  logic    dot_ok;
  logic signed [ACC_W-1:0] va [LANES];
  logic signed [ACC_W-1:0] vb [LANES];
  logic signed [ACC_W-1:0] vc [LANES];
  logic signed [ACC_W-1:0] prod [LANES];
  logic signed [ACC_W-1:0] dot3, dot4;

  assign opc = pso_op_e'(op);

  generate
    if (DOT_EN != 0) begin : g_dot
      assign dot_ok = 1'b1;
    end else begin : g_nodot
      assign dot_ok = 1'b0;
    end
  endgenerate

  assign is_dot = dot_ok && (opc == OP_DP3 || opc == OP_DP4);

  always_comb begin
    dot3 = '0;
    dot4 = '0;
    for (int i = 0; i < LANES; i++) begin
      va[i]   = widen(src_a[i*DATA_W +: DATA_W], neg[0]);
      vb[i]   = widen(src_b[i*DATA_W +: DATA_W], neg[1]);
      vc[i]   = widen(src_c[i*DATA_W +: DATA_W], neg[2]);
      prod[i] = va[i] * vb[i];
      if (i < 3) dot3 = dot3 + prod[i];
      if (i < 4) dot4 = dot4 + prod[i];
    end
    for (int i = 0; i < LANES; i++) begin
      // All results carry 2*FRAC_W fraction bits.
      case (opc)
        OP_ADD:  acc[i*ACC_W +: ACC_W] = (va[i] + vb[i]) <<< FRAC_W;
        OP_SUB:  acc[i*ACC_W +: ACC_W] = (va[i] - vb[i]) <<< FRAC_W;
        OP_MUL:  acc[i*ACC_W +: ACC_W] = prod[i];
        OP_MAD:  acc[i*ACC_W +: ACC_W] = prod[i] + (vc[i] <<< FRAC_W);
        OP_DP3:  acc[i*ACC_W +: ACC_W] = dot_ok ? dot3 : '0;
        OP_DP4:  acc[i*ACC_W +: ACC_W] = dot_ok ? dot4 : '0;
        default: acc[i*ACC_W +: ACC_W] = '0;
      endcase
    end
  end

endmodule

// File: rtl/pso_lanemod.sv
module pso_lanemod
  import pso_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int FRAC_W = 10,
  parameter int ACC_W  = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [ACC_W-1:0]  acc,
  input  logic [2:0]        scale,
  input  logic              abs_en,
  input  logic              sat_en,
  output logic [DATA_W-1:0] res
);

  localparam int GUARD = 3;
  localparam int EXT_W = ACC_W + GUARD + 1;
  localparam logic signed [EXT_W-1:0] MAXV = EXT_W'((1 <<< (DATA_W-1)) - 1);
  localparam logic signed [EXT_W-1:0] MINV = -MAXV - EXT_W'(1);
  localparam logic signed [EXT_W-1:0] ONEV = EXT_W'(1 <<< FRAC_W);

  // Scale and drop back to FRAC_W fraction bits in one rounding shift.
  function automatic logic signed [EXT_W-1:0] rescale(input logic signed [ACC_W-1:0] v,
                                                      input logic [2:0] code);
    logic signed [EXT_W-1:0] w, half;
    int sh;
    sh   = scale_rshift(code, FRAC_W + GUARD);
    w    = EXT_W'(v) <<< GUARD;
    half = EXT_W'(1) <<< (sh - 1);
    return (w + half) >>> sh;
  endfunction

  logic signed [EXT_W-1:0] scaled, mag, hi_lim, lo_lim;
  logic clip_hi, clip_lo;

  assign scaled  = rescale($signed(acc), scale);
  assign mag     = (abs_en && scaled < 0) ? -scaled : scaled;
  assign hi_lim  = sat_en ? ONEV : MAXV;
  assign lo_lim  = sat_en ? '0   : MINV;
  assign clip_hi = mag > hi_lim;
  assign clip_lo = mag < lo_lim;
  assign res     = clip_hi ? hi_lim[DATA_W-1:0] :
                   clip_lo ? lo_lim[DATA_W-1:0] : mag[DATA_W-1:0];

  p_sat_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && sat_en) |-> (!res[DATA_W-1] && $signed(res) <= $signed(ONEV[DATA_W-1:0])));

  p_abs_nonneg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && abs_en) |-> !res[DATA_W-1]);

  p_clip_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sat_en && clip_hi) |-> (res == MAXV[DATA_W-1:0]));

  p_clip_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sat_en && clip_lo) |-> (res == MINV[DATA_W-1:0]));

endmodule

// File: rtl/pso_alu.sv
module pso_alu
  import pso_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int FRAC_W = 10,
  parameter int LANES  = 4,
  parameter int DOT_EN = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [2:0]              in_op,
  input  logic [LANES*DATA_W-1:0] in_src_a,
  input  logic [LANES*DATA_W-1:0] in_src_b,
  input  logic [LANES*DATA_W-1:0] in_src_c,
  input  logic [2:0]              in_neg,
  input  logic [LANES-1:0]        in_mask,
  input  logic [2:0]              in_scale,
  input  logic                    in_abs,
  input  logic                    in_sat,
  output logic                    out_valid,
  output logic [LANES-1:0]        out_we,
  output logic [LANES*DATA_W-1:0] out_data
);

  localparam int ACC_W = 2 * (DATA_W + 1) + 2;
  localparam int VEC_W = LANES * DATA_W;

  logic [LANES*ACC_W-1:0] op_acc;
  logic                   op_dot;

  logic                   s1_valid, s1_abs, s1_sat, s1_dot;
  logic [LANES*ACC_W-1:0] s1_acc;
  logic [2:0]             s1_scale;
  logic [LANES-1:0]       s1_mask;
  logic                   out_dot;

  logic [VEC_W-1:0]       lane_res, lane_kept;

  pso_opstage #(
    .DATA_W(DATA_W), .FRAC_W(FRAC_W), .LANES(LANES), .DOT_EN(DOT_EN), .ACC_W(ACC_W)
  ) u_op (
    .op(in_op), .src_a(in_src_a), .src_b(in_src_b), .src_c(in_src_c),
    .neg(in_neg), .acc(op_acc), .is_dot(op_dot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_acc   <= '0;
      s1_scale <= '0;
      s1_abs   <= 1'b0;
      s1_sat   <= 1'b0;
      s1_mask  <= '0;
      s1_dot   <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      s1_acc   <= op_acc;
      s1_scale <= in_scale;
      s1_abs   <= in_abs;
      s1_sat   <= in_sat;
      s1_mask  <= in_mask;
      s1_dot   <= op_dot;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pso_lanemod #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) u_mod (
      .clk(clk), .rst_n(rst_n), .active(s1_valid),
      .acc(s1_acc[g*ACC_W +: ACC_W]), .scale(s1_scale),
      .abs_en(s1_abs), .sat_en(s1_sat),
      .res(lane_res[g*DATA_W +: DATA_W])
    );
    assign lane_kept[g*DATA_W +: DATA_W] =
      (s1_valid && s1_mask[g]) ? lane_res[g*DATA_W +: DATA_W] : '0;

    p_masked_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !out_we[g] |-> (out_data[g*DATA_W +: DATA_W] == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_we    <= '0;
      out_data  <= '0;
      out_dot   <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      out_we    <= s1_valid ? s1_mask : '0;
      out_data  <= lane_kept;
      out_dot   <= s1_valid && s1_dot;
    end
  end

  p_latency_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  p_latency_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);

  p_mask_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 (out_we == $past(in_mask, 2)));

  p_dot_replicate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_dot && (&out_we)) |-> (out_data == {LANES{out_data[DATA_W-1:0]}}));

endmodule

// File: tb/sim_pso_alu.sv
module sim_pso_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  in_op = '0;
  logic [47:0] in_src_a = '0, in_src_b = '0, in_src_c = '0;
  logic [2:0]  in_neg = '0;
  logic [3:0]  in_mask = '0;
  logic [2:0]  in_scale = '0;
  logic        in_abs = 1'b0, in_sat = 1'b0;
  logic        out_valid;
  logic [3:0]  out_we;
  logic [47:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  pso_alu #(.DATA_W(12), .FRAC_W(10), .LANES(4), .DOT_EN(1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_src_c(in_src_c),
    .in_neg(in_neg), .in_mask(in_mask), .in_scale(in_scale),
    .in_abs(in_abs), .in_sat(in_sat),
    .out_valid(out_valid), .out_we(out_we), .out_data(out_data)
  );

  function automatic logic [47:0] v4(input int x0, input int x1, input int x2, input int x3);
    return {12'(x3), 12'(x2), 12'(x1), 12'(x0)};
  endfunction

  // Reference model in real arithmetic; every value is a multiple of 2^-20.
  function automatic logic [47:0] model(input int op, input logic [47:0] a, input logic [47:0] b,
                                        input logic [47:0] c, input logic [2:0] ng,
                                        input logic [3:0] m, input int sc,
                                        input bit ab, input bit st);
    real va[4], vb[4], vc[4];
    real d3, d4, f, r;
    int q;
    logic [47:0] o;
    for (int i = 0; i < 4; i++) begin
      va[i] = $itor($signed(a[12*i +: 12])) / 1024.0;
      vb[i] = $itor($signed(b[12*i +: 12])) / 1024.0;
      vc[i] = $itor($signed(c[12*i +: 12])) / 1024.0;
      if (ng[0]) va[i] = -va[i];
      if (ng[1]) vb[i] = -vb[i];
      if (ng[2]) vc[i] = -vc[i];
    end
    d3 = va[0]*vb[0] + va[1]*vb[1] + va[2]*vb[2];
    d4 = d3 + va[3]*vb[3];
    case (sc)
      1: f = 2.0;   2: f = 4.0;   3: f = 8.0;
      4: f = 0.5;   5: f = 0.25;  6: f = 0.125;
      default: f = 1.0;
    endcase
    o = '0;
    for (int i = 0; i < 4; i++) begin
      case (op)
        0: r = va[i] + vb[i];
        1: r = va[i] - vb[i];
        2: r = va[i] * vb[i];
        3: r = va[i] * vb[i] + vc[i];
        4: r = d3;
        5: r = d4;
        default: r = 0.0;
      endcase
      q = $rtoi($floor(r * f * 1024.0 + 0.5));
      if (ab && q < 0) q = -q;
      if (st) begin
        if (q > 1024) q = 1024;
        if (q < 0) q = 0;
      end else begin
        if (q > 2047) q = 2047;
        if (q < -2048) q = -2048;
      end
      if (m[i]) o[12*i +: 12] = 12'(q);
    end
    return o;
  endfunction

  task automatic check_vec(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [47:0] a, input logic [47:0] b,
                       input logic [47:0] c, input logic [2:0] ng, input logic [3:0] m,
                       input logic [2:0] sc, input bit ab, input bit st);
    in_valid = 1'b1; in_op = op; in_src_a = a; in_src_b = b; in_src_c = c;
    in_neg = ng; in_mask = m; in_scale = sc; in_abs = ab; in_sat = st;
  endtask

  // Issue one instruction, check it two edges later, return the data.
  task automatic run_one(input string tag, input logic [2:0] op, input logic [47:0] a,
                         input logic [47:0] b, input logic [47:0] c, input logic [2:0] ng,
                         input logic [3:0] m, input logic [2:0] sc, input bit ab,
                         input bit st, output logic [47:0] got);
    logic [47:0] exp;
    exp = model(int'(op), a, b, c, ng, m, int'(sc), ab, st);
    @(negedge clk);
    drive(op, a, b, c, ng, m, sc, ab, st);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    got = out_data;
    check_vec({tag, " valid/we"}, {43'd0, out_valid, out_we}, {43'd0, 1'b1, m});
    check_vec({tag, " data"}, out_data, exp);
  endtask

  task automatic t_reset;
    check_vec("R11 reset state", {out_valid, out_we, out_data}, '0);
  endtask

  task automatic t_add_sub;
    logic [47:0] g;
    run_one("R1 add", 3'd0, v4(512, 1024, -300, 100), v4(256, -512, -300, 7), '0,
            3'b000, 4'hF, 3'd0, 0, 0, g);
    run_one("R1 sub", 3'd1, v4(512, 1024, -300, 100), v4(256, -512, -300, 7), '0,
            3'b000, 4'hF, 3'd0, 0, 0, g);
    run_one("R1 add negated b", 3'd0, v4(700, -50, 1000, 0), v4(300, 50, -900, 9), '0,
            3'b010, 4'hF, 3'd0, 0, 0, g);
    run_one("R1 sub negated a", 3'd1, v4(700, -50, 1000, 0), v4(300, 50, -900, 9), '0,
            3'b001, 4'hF, 3'd0, 0, 0, g);
  endtask

  task automatic t_mul;
    logic [47:0] g;
    run_one("R2 mul", 3'd2, v4(512, -768, 1536, 3), v4(512, 1024, 1536, 341), '0,
            3'b000, 4'hF, 3'd0, 0, 0, g);
  endtask

  task automatic t_mad;
    logic [47:0] g;
    // 1.5*1.5 = 2.25 leaves range; c = -1 brings it back to 1.25 (1280).
    run_one("R3 mad", 3'd3, v4(1536, -2048, 1, 512), v4(1536, -2048, 1, 512),
            v4(-1024, -2047, 0, 100), 3'b000, 4'hF, 3'd0, 0, 0, g);
    check_vec("R3 mad no intermediate clamp lane0", {36'd0, g[11:0]}, {36'd0, 12'd1280});
    run_one("R3 mad negated c", 3'd3, v4(1024, 300, -700, 5), v4(1024, 200, 600, 5),
            v4(1024, 50, -400, 5), 3'b100, 4'hF, 3'd0, 0, 0, g);
  endtask

  task automatic t_dot;
    logic [47:0] g;
    run_one("R4 dp3", 3'd4, v4(512, 256, -1024, 1024), v4(1024, 1024, 512, 1024), '0,
            3'b000, 4'hF, 3'd0, 0, 0, g);
    run_one("R4 dp4", 3'd5, v4(512, 256, -1024, 1024), v4(1024, 1024, 512, 1024), '0,
            3'b000, 4'hF, 3'd0, 0, 0, g);
  endtask

  task automatic t_scale;
    logic [47:0] g;
    for (int s = 0; s < 8; s++) begin
      run_one($sformatf("R5 scale code %0d", s), 3'd0, v4(3, -3, 1536, -1), v4(0, 0, 0, 0),
              '0, 3'b000, 4'hF, 3'(s), 0, 0, g);
    end
  endtask

  task automatic t_abs;
    logic [47:0] g;
    run_one("R6 abs unsat", 3'd0, v4(-1536, -300, 400, -2048), v4(-1536, -20, 0, 0), '0,
            3'b000, 4'hF, 3'd0, 1, 0, g);
    run_one("R6 abs with sat", 3'd0, v4(-512, -1536, 200, 0), v4(0, 0, 0, 0), '0,
            3'b000, 4'hF, 3'd0, 1, 1, g);
  endtask

  task automatic t_clamp;
    logic [47:0] g;
    run_one("R7 range clamp", 3'd0, v4(-2048, 2047, 1024, -1024), v4(-2048, 2047, 1023, -1024),
            '0, 3'b000, 4'hF, 3'd0, 0, 0, g);
    run_one("R8 saturate", 3'd0, v4(1024, -512, 512, 1023), v4(512, 0, 0, 1), '0,
            3'b000, 4'hF, 3'd0, 0, 1, g);
  endtask

  task automatic t_mask;
    logic [47:0] g;
    run_one("R9 mask 0101", 3'd0, v4(100, 200, 300, 400), v4(1, 2, 3, 4), '0,
            3'b000, 4'b0101, 3'd0, 0, 0, g);
    run_one("R9 mask 1000", 3'd2, v4(100, 200, 300, 400), v4(1024, 1024, 1024, 1024), '0,
            3'b000, 4'b1000, 3'd0, 0, 0, g);
  endtask

  task automatic t_stream;
    logic [47:0] ea, eb, ec;
    ea = model(0, v4(1, 2, 3, 4), v4(10, 10, 10, 10), '0, 3'b000, 4'hF, 0, 0, 0);
    eb = model(2, v4(512, 512, 512, 512), v4(100, 200, 300, 400), '0, 3'b000, 4'hF, 0, 0, 0);
    ec = model(1, v4(0, 0, 0, 0), v4(5, 6, 7, 8), '0, 3'b000, 4'hF, 1, 0, 0);
    @(negedge clk);
    drive(3'd0, v4(1, 2, 3, 4), v4(10, 10, 10, 10), '0, 3'b000, 4'hF, 3'd0, 0, 0);
    @(negedge clk);
    drive(3'd2, v4(512, 512, 512, 512), v4(100, 200, 300, 400), '0, 3'b000, 4'hF, 3'd0, 0, 0);
    @(negedge clk);
    drive(3'd1, v4(0, 0, 0, 0), v4(5, 6, 7, 8), '0, 3'b000, 4'hF, 3'd1, 0, 0);
    check_vec("R10 back-to-back first", {out_valid, out_data}, {1'b1, ea});
    @(negedge clk);
    in_valid = 1'b0;
    check_vec("R10 back-to-back second", {out_valid, out_data}, {1'b1, eb});
    @(negedge clk);
    check_vec("R10 back-to-back third", {out_valid, out_data}, {1'b1, ec});
    @(negedge clk);
    check_vec("R10 valid drops", {47'd0, out_valid}, '0);
  endtask

  task automatic t_chain;
    logic [47:0] g1, g2, g3, ones;
    ones = v4(1024, 1024, 1024, 1024);
    run_one("R12 step1 sat add", 3'd0, ones, ones, '0, 3'b000, 4'hF, 3'd0, 0, 1, g1);
    run_one("R12 step2 sat add", 3'd0, g1, ones, '0, 3'b000, 4'hF, 3'd0, 0, 1, g2);
    run_one("R12 step3 add negated", 3'd0, g2, ones, '0, 3'b010, 4'hF, 3'd0, 0, 1, g3);
    // Folding the three into one sum would give 1.0; stepwise gives 0.
    check_vec("R12 chain result", g3, '0);
  endtask

  task automatic t_reserved;
    logic [47:0] g;
    run_one("R13 opcode 6", 3'd6, v4(700, -700, 1024, 5), v4(700, 700, 1024, 5),
            v4(1, 1, 1, 1), 3'b000, 4'hF, 3'd0, 0, 0, g);
    run_one("R13 opcode 7", 3'd7, v4(700, -700, 1024, 5), v4(700, 700, 1024, 5),
            v4(1, 1, 1, 1), 3'b111, 4'hF, 3'd3, 1, 0, g);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add_sub();
    t_mul();
    t_mad();
    t_dot();
    t_scale();
    t_abs();
    t_clamp();
    t_mask();
    t_stream();
    t_chain();
    t_reserved();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule